// File: doc/BRIEF.md
# SPI FIFO Status and Edge Interrupt Unit

This unit sits beside the transmit and receive FIFOs of an SPI controller. It follows the occupancy of both queues from their push and pop strobes. From that occupancy it derives a twelve-bit level status word: empty, full, a ready flag that compares against a per-queue threshold, and sticky overflow and underflow error flags. The two transfer-progress indications of the shift engine are folded into the same word.

Software is told about status changes through one interrupt line. A bit of the cause register is set only when the matching status bit goes from 0 to 1. A bit that is already high therefore never raises a second interrupt, and software must look at the level word before it waits. Cause bits are cleared by writing ones. They reach the interrupt line only through a mask register. A flush request empties both queues' bookkeeping and clears the error flags. A busy flag shows the flush in progress and drops by itself when the flush is over.

The FIFO storage itself, the register bus decode and the shift engine are outside this unit.

Top module: `spi_fifo_irq_status`

## Requirements
- R1: Status bit 0 equals `xfer_done_i` and status bit 1 equals `xfer_ready_i` in the same cycle.
- R2: Each queue holds DEPTH one-byte slots. A push adds one byte and a pop removes one, and the count changes at the clock edge that samples the strobe. Status bit 4 means read queue empty, bit 5 read queue full, bit 6 write queue empty and bit 7 write queue full.
- R3: Status bit 2 is high while the read queue count is greater than `cfg_i[26:24]`. Status bit 3 is high while the write queue free space (DEPTH minus count) is greater than `cfg_i[30:28]`. The other bits of `cfg_i` have no effect.
- R4: A push to a full queue is dropped and sets an overflow flag. A pop from an empty queue is dropped and sets an underflow flag. The flags are status bit 8 for read underflow, bit 9 for read overflow, bit 10 for write underflow and bit 11 for write overflow. They stay set until a flush or a reset. A push and a pop on a full queue in the same cycle are both accepted, and neither flag is set.
- R5: The edge that samples `flush_req_i` high zeroes both counts and all four error flags and raises `flush_busy_o`. The flag stays high for FLUSH_CYCLES cycles and then clears by itself. Pushes and pops during the flush are ignored.
- R6: A cause bit is set only at the edge after its status bit goes from 0 to 1. A status bit that stays high sets nothing more, and bits already high when reset is released set nothing.
- R7: A clear write (`cause_clr_we_i`) clears each cause bit whose `cause_clr_i` bit is 1 and leaves the others. Writing all ones clears every cause bit.
- R8: A 0-to-1 status edge in the same cycle as a clear write of its cause bit leaves that cause bit set.
- R9: `irq_o` is the OR of the cause bits whose mask bits are set. The mask is loaded from `mask_i` when `mask_we_i` is high, and a zero mask keeps `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 32 | Configuration word; the read threshold is at [26:24] and the write threshold at [30:28] |
| xfer_done_i | input | 1 | Transfer-done level from the shift engine |
| xfer_ready_i | input | 1 | Transfer-ready level from the shift engine |
| wf_push_i | input | 1 | One byte written into the write queue |
| wf_pop_i | input | 1 | One byte taken from the write queue by the shift engine |
| rf_push_i | input | 1 | One byte delivered into the read queue by the shift engine |
| rf_pop_i | input | 1 | One byte read out of the read queue |
| flush_req_i | input | 1 | Request to empty both queues |
| cause_clr_we_i | input | 1 | Write strobe for the cause clear |
| cause_clr_i | input | 12 | Ones clear the matching cause bits |
| mask_we_i | input | 1 | Write strobe for the mask |
| mask_i | input | 12 | New mask value |
| status_o | output | 12 | Level status word |
| cause_o | output | 12 | Latched rising-edge causes |
| mask_o | output | 12 | Current mask |
| irq_o | output | 1 | Interrupt line |
| flush_busy_o | output | 1 | Flush in progress |

## Verification
On every cycle the assertions check that counts stay bounded, that the error flags stick and that a dropped push or pop sets its flag. They also check that a flush leaves both queues empty and error-free, and that each cause bit follows its status edge under clear writes and the race between an edge and a clear. Only the bench scenarios can show the exact threshold boundaries, that unrelated configuration bits have no effect, how long the flush lasts and that strobes are ignored during it. They also show that a held level never raises a second cause and the masked interrupt behaviour over a full sequence. The scenarios compare these against a reference model that runs beside the design.

// File: rtl/spi_fstat_pkg.sv
package spi_fstat_pkg;
   localparam int STAT_W     = 12;
   localparam int CFG_W      = 32;
   localparam int TH_W       = 3;
   localparam int RD_TH_LSB  = 24;
   localparam int WR_TH_LSB  = 28;
   localparam int B_XDONE    = 0;
   localparam int B_XRDY     = 1;
   localparam int B_RRDY     = 2;
   localparam int B_WRDY     = 3;
   localparam int B_REMPTY   = 4;
   localparam int B_RFULL    = 5;
   localparam int B_WEMPTY   = 6;
   localparam int B_WFULL    = 7;
   localparam int B_RUNF     = 8;
   localparam int B_ROVF     = 9;
   localparam int B_WUNF     = 10;
   localparam int B_WOVF     = 11;
endpackage

// File: rtl/spi_fifo_level.sv
module spi_fifo_level #(
   parameter int DEPTH         = 8,
   parameter int TH_W          = 3,
   parameter bit READY_ON_FREE = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [TH_W-1:0] thresh_i,
   output logic            empty_o,
   output logic            full_o,
   output logic            ready_o,
   output logic            ovf_o,
   output logic            unf_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int CMP_W = ((CNT_W > TH_W) ? CNT_W : TH_W) + 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_fifo_level: DEPTH must be at least 2");
   end

   logic [CNT_W-1:0] level_q;
   logic             ovf_q, unf_q;
   logic             push_ok, pop_ok;
   logic [CMP_W-1:0] cmp_lhs, cmp_thr;

   assign pop_ok  = pop_i && (level_q != '0);
   assign push_ok = push_i && ((level_q != CNT_W'(DEPTH)) || pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else if (clear_i) begin
         level_q <= '0;
         ovf_q   <= 1'b0;
         unf_q   <= 1'b0;
      end else begin
         level_q <= level_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
         if (push_i && !push_ok) ovf_q <= 1'b1;
         if (pop_i && !pop_ok)   unf_q <= 1'b1;
      end
   end

   if (READY_ON_FREE) begin : g_free_space
      assign cmp_lhs = CMP_W'(CNT_W'(DEPTH) - level_q);
   end else begin : g_occupancy
      assign cmp_lhs = CMP_W'(level_q);
   end
   assign cmp_thr = CMP_W'(thresh_i);

   assign ready_o = cmp_lhs > cmp_thr;
   assign empty_o = (level_q == '0);
   assign full_o  = (level_q == CNT_W'(DEPTH));
   assign ovf_o   = ovf_q;
   assign unf_o   = unf_q;

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= CNT_W'(DEPTH)); // R2
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o && !clear_i |=> ovf_o); // R4
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      unf_o && !clear_i |=> unf_o); // R4
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      push_i && !pop_i && full_o && !clear_i |=> ovf_o && full_o); // R4
   AST_UNF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i && !push_i && empty_o && !clear_i |=> unf_o && empty_o); // R4
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> empty_o && !ovf_o && !unf_o); // R5
endmodule

// File: rtl/spi_flush_seq.sv
module spi_flush_seq #(
   parameter int FLUSH_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic clear_o,
   output logic busy_o
);
   localparam int TW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;

   if (FLUSH_CYCLES < 1) begin : g_bad_len
      $error("spi_flush_seq: FLUSH_CYCLES must be at least 1");
   end

   logic          busy_q;
   logic [TW-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tmr_q  <= '0;
      end else if (busy_q) begin
         if (tmr_q == TW'(FLUSH_CYCLES - 1)) begin
            busy_q <= 1'b0;
            tmr_q  <= '0;
         end else begin
            tmr_q <= tmr_q + TW'(1);
         end
      end else if (req_i) begin
         busy_q <= 1'b1;
         tmr_q  <= '0;
      end
   end

   assign clear_o = req_i | busy_q;
   assign busy_o  = busy_q;

   AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      req_i && !busy_o |=> busy_o); // R5
endmodule

// File: rtl/spi_edge_cause.sv
module spi_edge_cause #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_data_i,
   input  logic         mask_we_i,
   input  logic [W-1:0] mask_data_i,
   output logic [W-1:0] cause_o,
   output logic [W-1:0] mask_o,
   output logic         irq_o
);
   if (W < 1) begin : g_bad_width
      $error("spi_edge_cause: W must be at least 1");
   end

   logic [W-1:0] stat_q, cause_q, mask_q, rise, clr_sel;

   assign rise    = stat_i & ~stat_q;
   assign clr_sel = clr_we_i ? clr_data_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '1;
         cause_q <= '0;
         mask_q  <= '0;
      end else begin
         stat_q  <= stat_i;
         cause_q <= (cause_q & ~clr_sel) | rise;
         if (mask_we_i) mask_q <= mask_data_i;
      end
   end

   assign cause_o = cause_q;
   assign mask_o  = mask_q;
   assign irq_o   = |(cause_q & mask_q);

   for (genvar i = 0; i < W; i++) begin : g_bit_chk
      AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && stat_i[i] && !$past(stat_i[i]) |=> cause_o[i]); // R6
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && !cause_o[i] && !(stat_i[i] && !$past(stat_i[i]))
         |=> !cause_o[i]); // R6
      AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && clr_we_i && clr_data_i[i] && !(stat_i[i] && !$past(stat_i[i]))
         |=> !cause_o[i]); // R7
      AST_CLR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) && clr_we_i && clr_data_i[i] && stat_i[i] && !$past(stat_i[i])
         |=> cause_o[i]); // R8
   end

   AST_MASK_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o == '0) |-> !irq_o); // R9
endmodule

// File: rtl/spi_fifo_irq_status.sv
module spi_fifo_irq_status
   import spi_fstat_pkg::*;
#(
   parameter int DEPTH        = 8,
   parameter int FLUSH_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic              xfer_done_i,
   input  logic              xfer_ready_i,
   input  logic              wf_push_i,
   input  logic              wf_pop_i,
   input  logic              rf_push_i,
   input  logic              rf_pop_i,
   input  logic              flush_req_i,
   input  logic              cause_clr_we_i,
   input  logic [STAT_W-1:0] cause_clr_i,
   input  logic              mask_we_i,
   input  logic [STAT_W-1:0] mask_i,
   output logic [STAT_W-1:0] status_o,
   output logic [STAT_W-1:0] cause_o,
   output logic [STAT_W-1:0] mask_o,
   output logic              irq_o,
   output logic              flush_busy_o
);
   if (DEPTH < (1 << TH_W)) begin : g_bad_depth
      $error("spi_fifo_irq_status: DEPTH must cover the full threshold range");
   end

   logic              fl_clear;
   logic              w_empty, w_full, w_ready, w_ovf, w_unf;
   logic              r_empty, r_full, r_ready, r_ovf, r_unf;
   logic [STAT_W-1:0] stat;
   logic              unused_cfg;

   assign unused_cfg = ^{cfg_i[CFG_W-1], cfg_i[WR_TH_LSB-1], cfg_i[RD_TH_LSB-1:0]};

   spi_flush_seq #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_flush (
      .clk(clk), .rst_n(rst_n), .req_i(flush_req_i),
      .clear_o(fl_clear), .busy_o(flush_busy_o)
   );

   spi_fifo_level #(.DEPTH(DEPTH), .TH_W(TH_W), .READY_ON_FREE(1'b1)) u_wlvl (
      .clk(clk), .rst_n(rst_n), .clear_i(fl_clear),
      .push_i(wf_push_i), .pop_i(wf_pop_i),
      .thresh_i(cfg_i[WR_TH_LSB +: TH_W]),
      .empty_o(w_empty), .full_o(w_full), .ready_o(w_ready),
      .ovf_o(w_ovf), .unf_o(w_unf)
   );

   spi_fifo_level #(.DEPTH(DEPTH), .TH_W(TH_W), .READY_ON_FREE(1'b0)) u_rlvl (
      .clk(clk), .rst_n(rst_n), .clear_i(fl_clear),
      .push_i(rf_push_i), .pop_i(rf_pop_i),
      .thresh_i(cfg_i[RD_TH_LSB +: TH_W]),
      .empty_o(r_empty), .full_o(r_full), .ready_o(r_ready),
      .ovf_o(r_ovf), .unf_o(r_unf)
   );

   always_comb begin
      stat           = '0;
      stat[B_XDONE]  = xfer_done_i;
      stat[B_XRDY]   = xfer_ready_i;
      stat[B_RRDY]   = r_ready;
      stat[B_WRDY]   = w_ready;
      stat[B_REMPTY] = r_empty;
      stat[B_RFULL]  = r_full;
      stat[B_WEMPTY] = w_empty;
      stat[B_WFULL]  = w_full;
      stat[B_RUNF]   = r_unf;
      stat[B_ROVF]   = r_ovf;
      stat[B_WUNF]   = w_unf;
      stat[B_WOVF]   = w_ovf;
   end

   assign status_o = stat;

   spi_edge_cause #(.W(STAT_W)) u_cause (
      .clk(clk), .rst_n(rst_n), .stat_i(stat),
      .clr_we_i(cause_clr_we_i), .clr_data_i(cause_clr_i),
      .mask_we_i(mask_we_i), .mask_data_i(mask_i),
      .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o)
   );

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy_o |-> status_o[B_REMPTY] && status_o[B_WEMPTY]
                       && (status_o[B_WOVF:B_RUNF] == '0)); // R5
endmodule

// File: tb/spi_fifo_irq_status_tb.sv
`timescale 1ns/100ps
module spi_fifo_irq_status_tb;
   localparam int DEPTH = 8;
   localparam int FL    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_i = '0;
   logic        xfer_done_i = 0, xfer_ready_i = 0;
   logic        wf_push_i = 0, wf_pop_i = 0, rf_push_i = 0, rf_pop_i = 0;
   logic        flush_req_i = 0, cause_clr_we_i = 0, mask_we_i = 0;
   logic [11:0] cause_clr_i = '0, mask_i = '0;
   logic [11:0] status_o, cause_o, mask_o;
   logic        irq_o, flush_busy_o;

   int checks = 0, errors = 0;
   bit stop = 0;

   always #2.5 clk = ~clk;

   spi_fifo_irq_status #(.DEPTH(DEPTH), .FLUSH_CYCLES(FL)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
      .xfer_done_i(xfer_done_i), .xfer_ready_i(xfer_ready_i),
      .wf_push_i(wf_push_i), .wf_pop_i(wf_pop_i),
      .rf_push_i(rf_push_i), .rf_pop_i(rf_pop_i),
      .flush_req_i(flush_req_i),
      .cause_clr_we_i(cause_clr_we_i), .cause_clr_i(cause_clr_i),
      .mask_we_i(mask_we_i), .mask_i(mask_i),
      .status_o(status_o), .cause_o(cause_o), .mask_o(mask_o),
      .irq_o(irq_o), .flush_busy_o(flush_busy_o)
   );

   // reference model
   int          m_wc, m_rc, m_timer;
   bit          m_wovf, m_wunf, m_rovf, m_runf, m_busy;
   logic [11:0] m_prev, m_cause, m_mask;

   function automatic logic [11:0] m_status();
      logic [11:0] s;
      s[0]  = xfer_done_i;
      s[1]  = xfer_ready_i;
      s[2]  = m_rc > int'(cfg_i[26:24]);
      s[3]  = (DEPTH - m_wc) > int'(cfg_i[30:28]);
      s[4]  = (m_rc == 0);
      s[5]  = (m_rc == DEPTH);
      s[6]  = (m_wc == 0);
      s[7]  = (m_wc == DEPTH);
      s[8]  = m_runf;
      s[9]  = m_rovf;
      s[10] = m_wunf;
      s[11] = m_wovf;
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wc = 0; m_rc = 0; m_timer = 0; m_busy = 0;
         m_wovf = 0; m_wunf = 0; m_rovf = 0; m_runf = 0;
         m_prev = '1; m_cause = '0; m_mask = '0;
      end else begin
         logic [11:0] st, clr;
         bit wpo, wpu, rpo, rpu;
         st = m_status();
         clr = cause_clr_we_i ? cause_clr_i : '0;
         m_cause = (m_cause & ~clr) | (st & ~m_prev);
         m_prev = st;
         if (mask_we_i) m_mask = mask_i;
         if (flush_req_i || m_busy) begin
            m_wc = 0; m_rc = 0;
            m_wovf = 0; m_wunf = 0; m_rovf = 0; m_runf = 0;
            if (m_busy) begin
               if (m_timer == FL - 1) begin m_busy = 0; m_timer = 0; end
               else m_timer++;
            end else begin
               m_busy = 1; m_timer = 0;
            end
         end else begin
            wpo = wf_pop_i && m_wc > 0;
            wpu = wf_push_i && (m_wc < DEPTH || wpo);
            if (wf_pop_i && !wpo) m_wunf = 1;
            if (wf_push_i && !wpu) m_wovf = 1;
            m_wc = m_wc + int'(wpu) - int'(wpo);
            rpo = rf_pop_i && m_rc > 0;
            rpu = rf_push_i && (m_rc < DEPTH || rpo);
            if (rf_pop_i && !rpo) m_runf = 1;
            if (rf_push_i && !rpu) m_rovf = 1;
            m_rc = m_rc + int'(rpu) - int'(rpo);
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && !stop) begin
         logic [11:0] ms;
         ms = m_status();
         chk("R1 model transfer bits", 32'(status_o[1:0]), 32'(ms[1:0]));
         chk("R2 model level bits", 32'(status_o[7:2]), 32'(ms[7:2]));
         chk("R4 model error bits", 32'(status_o[11:8]), 32'(ms[11:8]));
         chk("R6 model cause", 32'(cause_o), 32'(m_cause));
         chk("R9 model irq", 32'(irq_o), 32'(|(m_cause & m_mask)));
         chk("R5 model busy", 32'(flush_busy_o), 32'(m_busy));
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wpush(int n);
      @(negedge clk); wf_push_i = 1;
      repeat (n) @(negedge clk);
      wf_push_i = 0;
   endtask

   task automatic rpush(int n);
      @(negedge clk); rf_push_i = 1;
      repeat (n) @(negedge clk);
      rf_push_i = 0;
   endtask

   task automatic rpop(int n);
      @(negedge clk); rf_pop_i = 1;
      repeat (n) @(negedge clk);
      rf_pop_i = 0;
   endtask

   task automatic clr_write(logic [11:0] v);
      @(negedge clk); cause_clr_we_i = 1; cause_clr_i = v;
      @(negedge clk); cause_clr_we_i = 0; cause_clr_i = '0;
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      if (!stop) begin
         stop = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [31:0] CFG = (32'd5 << 28) | (32'd2 << 24);

   initial begin
      idle(4);
      rst_n = 1;
      idle(2);
      #2;
      chk("R2 reset status", 32'(status_o), 32'h058);
      chk("R6 no cause at reset release", 32'(cause_o), 0);
      chk("R9 irq low after reset", 32'(irq_o), 0);
      chk("R5 not busy after reset", 32'(flush_busy_o), 0);

      @(negedge clk); cfg_i = CFG;
      idle(1); #2;
      chk("R3 write ready with free 8 over threshold 5", 32'(status_o[3]), 1);

      wpush(3); #2;
      chk("R3 write ready off when free equals threshold", 32'(status_o[3]), 0);
      chk("R2 write queue not empty", 32'(status_o), 32'h010);

      @(negedge clk); cfg_i = CFG | 32'h88FF_FFFF;
      #2;
      chk("R3 unrelated config bits ignored", 32'(status_o), 32'h010);
      @(negedge clk); cfg_i = CFG;

      wpush(5); idle(1); #2;
      chk("R2 write queue full", 32'(status_o[7]), 1);
      chk("R6 cause from full edge only", 32'(cause_o), 32'h080);
      chk("R9 zero mask keeps irq low", 32'(irq_o), 0);

      wpush(1); idle(1); #2;
      chk("R4 write overflow flag", 32'(status_o[11]), 1);
      chk("R4 count held at full", 32'(status_o[7]), 1);

      @(negedge clk); wf_push_i = 1; wf_pop_i = 1;
      @(negedge clk); wf_push_i = 0; wf_pop_i = 0;
      #2;
      chk("R4 push and pop on full: no underflow", 32'(status_o[10]), 0);
      chk("R4 push and pop on full: still full", 32'(status_o[7]), 1);

      @(negedge clk); mask_we_i = 1; mask_i = 12'h080;
      @(negedge clk); mask_we_i = 0;
      #2;
      chk("R9 masked cause drives irq", 32'(irq_o), 1);

      clr_write(12'h080); #2;
      chk("R7 selected cause cleared", 32'(cause_o[7]), 0);
      chk("R7 other cause kept", 32'(cause_o[11]), 1);
      chk("R9 irq drops with cause", 32'(irq_o), 0);

      clr_write(12'hFFF); #2;
      chk("R7 all-ones clear", 32'(cause_o), 0);

      rpush(3); #2;
      chk("R3 read ready above threshold 2", 32'(status_o[2]), 1);
      idle(1); #2;
      chk("R6 read ready edge cause", 32'(cause_o[2]), 1);

      rpop(4); #2;
      chk("R4 read underflow flag", 32'(status_o[8]), 1);
      chk("R2 read queue empty", 32'(status_o[4]), 1);

      @(negedge clk); xfer_done_i = 1;
      #2;
      chk("R1 transfer done visible same cycle", 32'(status_o[0]), 1);
      @(negedge clk); #2;
      chk("R6 transfer done edge cause", 32'(cause_o[0]), 1);
      clr_write(12'hFFF); #2;
      chk("R7 cleared while level held", 32'(cause_o[0]), 0);
      idle(2); #2;
      chk("R6 held level raises nothing", 32'(cause_o[0]), 0);
      @(negedge clk); xfer_done_i = 0;
      @(negedge clk); xfer_done_i = 1; cause_clr_we_i = 1; cause_clr_i = 12'h001;
      @(negedge clk); cause_clr_we_i = 0; cause_clr_i = '0;
      #2;
      chk("R8 edge wins over clear", 32'(cause_o[0]), 1);

      @(negedge clk); xfer_ready_i = 1;
      #2;
      chk("R1 transfer ready visible same cycle", 32'(status_o[1]), 1);

      @(negedge clk); flush_req_i = 1;
      @(negedge clk); flush_req_i = 0; wf_push_i = 1; rf_push_i = 1;
      #2;
      chk("R5 busy after request", 32'(flush_busy_o), 1);
      chk("R5 flush empties both queues", 32'(status_o[6] & status_o[4]), 1);
      chk("R5 flush clears error flags", 32'(status_o[11:8]), 0);
      @(negedge clk); wf_push_i = 0; rf_push_i = 0;
      #2;
      chk("R5 still busy second cycle", 32'(flush_busy_o), 1);
      @(negedge clk); #2;
      chk("R5 busy clears by itself", 32'(flush_busy_o), 0);
      chk("R5 pushes during flush ignored", 32'(status_o[6] & status_o[4]), 1);

      idle(3);
      stop = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule